// File: doc/BRIEF.md
# SPI Command-Queue Sequencer

This block is the control core of a master-mode SPI controller that works through a queue of up to sixteen commands held in an external command RAM. Software programs a timing register and a queue-control register, and then sets a run bit. The sequencer then fetches one command at a time. It drives that command's chip-select pattern, waits for a configurable lead time, and hands the serial transfer to a separate shift engine through a start/done handshake. After the transfer it waits for a configurable trail time and then moves to the next command.

Each command word holds a chip-select pattern in bits [CS_W-1:0], a lead-delay flag in bit CS_W and a trail-delay flag in bit CS_W+1. The command RAM is read combinationally at the address the sequencer presents. The queue either ends at a programmed end index or wraps around indefinitely. A wrap returns either to entry 0 or to the programmed start index. Software can pause the queue at a command boundary or abort it outright. An external lock input can protect the run bit from being cleared by software.

All delays are counted in system clock cycles. The default of one SPI clock period is the parameter SCK_PERIOD (4 by default).

Top module: `spi_qseq`

## Requirements
- R1: After reset, timing register (address 0) reads 0x0404, control register (address 1) reads 0x1000, xferStart is low and csOut is all ones.
- R2: Timing register layout: bit 15 = run, bits 14..8 = lead count L, bits 7..0 = trail count T; written fields read back unchanged.
- R3: Control register layout: bit 15 = pause, bit 14 = wrap on, bit 13 = wrap target (1 = start index, 0 = entry 0), bit 12 = idle chip-select level, bits 11..8 = end index, bits 7..4 = last-completed index (read-only), bits 3..0 = start index.
- R4: Setting run starts execution at the start index; entries are issued in ascending order (modulo 16), one single-cycle xferStart per entry, with cmdAddr equal to the entry index and csOut equal to its pattern.
- R5: With wrap off, the run bit clears by itself after the end-index command completes, and no further xferStart follows.
- R6: The last-completed field takes each command's index when that command finishes.
- R7: csOut is active for exactly N cycles before xferStart, where N = L (L = 0 gives 128) when the lead flag is set, and N = SCK_PERIOD when it is clear.
- R8: csOut stays active for exactly M cycles after the cycle in which xferDone is seen, where M = T (T = 0 gives 256) when the trail flag is set, and M = SCK_PERIOD when it is clear.
- R9: Setting pause lets the current command finish; no new command starts while pause is set, the run bit stays set, and clearing pause resumes at the next entry.
- R10: Writing run = 0 aborts the queue and returns csOut to the idle level within two cycles, unless abortLock is high; in that case the run bit stays set and execution continues.
- R11: With wrap on, the entry after the end index is entry 0 when the wrap target is 0, and the start index when it is 1.
- R12: Whenever no command is in its lead, transfer or trail phase, every csOut bit equals the idle chip-select level bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 timing, 1 control |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Read data of the selected register (combinational) |
| abortLock | input | 1 | When high, software cannot clear the run bit |
| cmdAddr | output | 4 | Command RAM read index |
| cmdData | input | CS_W+2 | Command word at cmdAddr |
| xferStart | output | 1 | One-cycle request to the shift engine |
| xferDone | input | 1 | One-cycle completion from the shift engine |
| csOut | output | CS_W | Chip-select outputs |

## Verification
The hardest condition to reach is a pause that arrives while a wrapped queue is mid-command. The bench starts a wrap-to-zero queue just below the top of the RAM. It watches the start log and sets pause right after the fourth start, once the index has crossed 15 to 0. It then checks that the command in flight completes, records its index, and that nothing else starts until pause is cleared. A zero lead and a zero trail count are run on a single-entry queue, so the full 128- and 256-cycle windows are measured edge by edge on csOut.

// File: rtl/spi_qseq_pkg.sv
package spi_qseq_pkg;
  localparam int PTR_W = 4;
  localparam int QCD_W = 7;
  localparam int DTL_W = 8;
  localparam int REG_W = 16;
  localparam int CNT_W = DTL_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_PRE, ST_START, ST_WAIT, ST_POST, ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic ptrLoadNew;
    logic ptrAdvance;
    logic cmdLatch;
    logic postLoad;
    logic cntDec;
    logic compLoad;
    logic clrEn;
    logic csActive;
  } seqCtl_t;
endpackage

// File: rtl/spi_qseq_datapath.sv
module spi_qseq_datapath
  import spi_qseq_pkg::*;
#(
  parameter int CS_W = 4,
  parameter int SCK_PERIOD = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic                regAddr,
  input  logic [REG_W-1:0]    regWdata,
  input  logic                abortLock,
  output logic [REG_W-1:0]    regRdata,
  input  logic [CS_W+1:0]     cmdData,
  output logic [PTR_W-1:0]    cmdAddr,
  output logic [CS_W-1:0]     csOut,
  input  seqCtl_t             ctl,
  output logic                enOut,
  output logic                haltOut,
  output logic                csivOut,
  output logic                cntZero,
  output logic                lastCmd
);
  localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(SCK_PERIOD - 1);
  localparam int LEAD_BIT  = CS_W;
  localparam int TRAIL_BIT = CS_W + 1;

  logic              enR, haltR, wrenR, wselR, csivR;
  logic [QCD_W-1:0]  qcdR;
  logic [DTL_W-1:0]  dtlR;
  logic [PTR_W-1:0]  endR, compR, newR, ptrR;
  logic [CS_W-1:0]   csR;
  logic [CNT_W-1:0]  cntR;

  logic [QCD_W-1:0]  qcdM1;
  logic [DTL_W-1:0]  dtlM1;
  logic [CNT_W-1:0]  leadCnt, trailCnt;
  logic [PTR_W-1:0]  nextPtr;
  logic              swClear;

  assign qcdM1    = qcdR - QCD_W'(1);
  assign dtlM1    = dtlR - DTL_W'(1);
  assign leadCnt  = cmdData[LEAD_BIT]  ? CNT_W'(qcdM1) : DEF_CNT;
  assign trailCnt = cmdData[TRAIL_BIT] ? CNT_W'(dtlM1) : DEF_CNT;
  assign nextPtr  = (ptrR == endR) ? (wselR ? newR : '0) : ptrR + PTR_W'(1);
  assign swClear  = regWr && !regAddr && !regWdata[15] && !abortLock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR  <= 1'b0;
      qcdR <= QCD_W'(4);
      dtlR <= DTL_W'(4);
    end else begin
      if (regWr && !regAddr) begin
        qcdR <= regWdata[14:8];
        dtlR <= regWdata[7:0];
        if (regWdata[15]) enR <= 1'b1;
        else if (swClear) enR <= 1'b0;
      end
      if (ctl.clrEn) enR <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltR <= 1'b0;
      wrenR <= 1'b0;
      wselR <= 1'b0;
      csivR <= 1'b1;
      endR  <= '0;
      newR  <= '0;
    end else if (regWr && regAddr) begin
      haltR <= regWdata[15];
      wrenR <= regWdata[14];
      wselR <= regWdata[13];
      csivR <= regWdata[12];
      endR  <= regWdata[11:8];
      newR  <= regWdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrR  <= '0;
      compR <= '0;
      csR   <= '0;
      cntR  <= '0;
    end else begin
      if (ctl.ptrLoadNew) ptrR <= newR;
      else if (ctl.ptrAdvance) ptrR <= nextPtr;
      if (ctl.compLoad) compR <= ptrR;
      if (ctl.cmdLatch) begin
        csR  <= cmdData[CS_W-1:0];
        cntR <= leadCnt;
      end else if (ctl.postLoad) begin
        cntR <= trailCnt;
      end else if (ctl.cntDec) begin
        cntR <= cntR - CNT_W'(1);
      end
    end
  end

  assign regRdata = regAddr ? {haltR, wrenR, wselR, csivR, endR, compR, newR}
                            : {enR, qcdR, dtlR};
  assign cmdAddr  = ptrR;
  assign csOut    = ctl.csActive ? csR : {CS_W{csivR}};
  assign enOut    = enR;
  assign haltOut  = haltR;
  assign csivOut  = csivR;
  assign cntZero  = (cntR == '0);
  assign lastCmd  = (ptrR == endR) && !wrenR;
endmodule

// File: rtl/spi_qseq_ctrl.sv
module spi_qseq_ctrl
  import spi_qseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enIn,
  input  logic    haltIn,
  input  logic    cntZero,
  input  logic    lastCmd,
  input  logic    xferDone,
  output logic    xferStart,
  output seqCtl_t ctl
);
  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    if (state != ST_IDLE && !enIn) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (enIn) begin
          ctl.ptrLoadNew = 1'b1;
          stateNxt       = ST_LOAD;
        end
        ST_LOAD: begin
          ctl.cmdLatch = 1'b1;
          stateNxt     = ST_PRE;
        end
        ST_PRE: begin
          if (cntZero) stateNxt = ST_START;
          else         ctl.cntDec = 1'b1;
        end
        ST_START: stateNxt = ST_WAIT;
        ST_WAIT: if (xferDone) begin
          ctl.postLoad = 1'b1;
          stateNxt     = ST_POST;
        end
        ST_POST: begin
          if (!cntZero) begin
            ctl.cntDec = 1'b1;
          end else begin
            ctl.compLoad = 1'b1;
            if (lastCmd) begin
              ctl.clrEn = 1'b1;
              stateNxt  = ST_IDLE;
            end else begin
              ctl.ptrAdvance = 1'b1;
              stateNxt       = haltIn ? ST_HOLD : ST_LOAD;
            end
          end
        end
        ST_HOLD: if (!haltIn) stateNxt = ST_LOAD;
        default: stateNxt = ST_IDLE;
      endcase
    end
    ctl.csActive = (state == ST_PRE) || (state == ST_START) ||
                   (state == ST_WAIT) || (state == ST_POST);
  end

  assign xferStart = (state == ST_START);
endmodule

// File: rtl/spi_qseq.sv
module spi_qseq
  import spi_qseq_pkg::*;
#(
  parameter int CS_W = 4,
  parameter int SCK_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              abortLock,
  output logic [3:0]        cmdAddr,
  input  logic [CS_W+1:0]   cmdData,
  output logic              xferStart,
  input  logic              xferDone,
  output logic [CS_W-1:0]   csOut
);
  seqCtl_t ctl;
  logic    enSig, haltSig, csivSig, cntZero, lastCmd;

  spi_qseq_datapath #(.CS_W(CS_W), .SCK_PERIOD(SCK_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .abortLock(abortLock), .regRdata(regRdata),
    .cmdData(cmdData), .cmdAddr(cmdAddr), .csOut(csOut), .ctl(ctl),
    .enOut(enSig), .haltOut(haltSig), .csivOut(csivSig),
    .cntZero(cntZero), .lastCmd(lastCmd)
  );

  spi_qseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enIn(enSig), .haltIn(haltSig),
    .cntZero(cntZero), .lastCmd(lastCmd), .xferDone(xferDone),
    .xferStart(xferStart), .ctl(ctl)
  );
endmodule

// File: rtl/spi_qseq_chk.sv
module spi_qseq_chk
  import spi_qseq_pkg::*;
#(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            xferStart,
  input logic            abortLock,
  input logic [CS_W-1:0] csOut,
  input logic            enSig,
  input logic            csivSig,
  input seqCtl_t         ctl
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart); // R4

  AST_START_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> enSig); // R10

  AST_IDLE_CS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !enSig |=> (csOut == {CS_W{csivSig}})); // R12

  AST_LOCK_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(enSig) && $past(abortLock)) |-> $past(ctl.clrEn)); // R10
endmodule

bind spi_qseq spi_qseq_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rstN(rstN), .xferStart(xferStart), .abortLock(abortLock),
  .csOut(csOut), .enSig(enSig), .csivSig(csivSig), .ctl(ctl)
);

// File: tb/spi_qseq_tb.sv
module spi_qseq_tb;
  localparam int CSW = 4;
  localparam int SCK = 4;
  localparam int XL  = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 1'b0, regAddr = 1'b0, abortLock = 1'b0, xferDone = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [3:0]  cmdAddr;
  logic [CSW+1:0] cmdData;
  logic xferStart;
  logic [CSW-1:0] csOut;
  logic [CSW+1:0] ram [16];

  int nChecks = 0, nErrors = 0, cycles = 0, engCnt = 0;
  int nStarts = 0, nPost = 0, csRun = 0, postCnt = 0;
  bit postOn = 0;
  bit tbCsiv = 1'b1;
  int startIdx [64];
  int startCs  [64];
  int preLen   [64];
  int postLen  [64];

  always #10 clk = ~clk;

  assign cmdData = ram[cmdAddr];

  spi_qseq #(.CS_W(CSW), .SCK_PERIOD(SCK)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .abortLock(abortLock),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .xferStart(xferStart),
    .xferDone(xferDone), .csOut(csOut)
  );

  // shift engine model
  always @(negedge clk) begin
    xferDone <= 1'b0;
    if (engCnt > 0) begin
      engCnt <= engCnt - 1;
      if (engCnt == 1) xferDone <= 1'b1;
    end else if (xferStart) begin
      engCnt <= XL;
    end
  end

  // port monitor
  always @(posedge clk) begin
    bit act;
    act = (csOut != {CSW{tbCsiv}});
    if (xferStart && nStarts < 64) begin
      startIdx[nStarts] = cmdAddr;
      startCs[nStarts]  = csOut;
      preLen[nStarts]   = csRun;
      nStarts++;
    end
    if (postOn) begin
      if (act) postCnt++;
      else begin
        if (nPost < 64) postLen[nPost] = postCnt;
        nPost++;
        postOn = 0;
      end
    end
    if (xferDone) begin
      postOn = 1;
      postCnt = 0;
    end
    csRun = act ? csRun + 1 : 0;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nErrors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input bit a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input bit a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic writeCtl(input bit h, input bit w, input bit s, input bit cv,
                          input logic [3:0] e, input logic [3:0] n);
    tbCsiv = cv;
    writeReg(1'b1, {h, w, s, cv, e, 4'h0, n});
  endtask

  task automatic clearLog();
    nStarts = 0; nPost = 0; postOn = 0; csRun = 0;
  endtask

  task automatic waitIdle();
    logic [15:0] d;
    d = 16'h8000;
    while (d[15]) readReg(1'b0, d);
  endtask

  task automatic waitStarts(input int n);
    while (nStarts < n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    readReg(1'b0, d); chk(d == 16'h0404, "R1 timing reset", d, 16'h0404);
    readReg(1'b1, d); chk(d == 16'h1000, "R1 control reset", d, 16'h1000);
    chk(csOut == 4'hF, "R1 cs reset", csOut, 4'hF);
    chk(xferStart == 1'b0, "R1 start reset", xferStart, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    writeReg(1'b0, 16'h2A96);
    readReg(1'b0, d); chk(d == 16'h2A96, "R2 timing fields", d, 16'h2A96);
    writeCtl(1'b0, 1'b0, 1'b1, 1'b1, 4'hB, 4'h5);
    readReg(1'b1, d); chk(d == 16'h3B05, "R3 control fields", d, 16'h3B05);
    writeReg(1'b1, 16'h30F5);
    readReg(1'b1, d); chk(d[7:4] == 4'h0, "R3 completed field read-only", d[7:4], 0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    ram[2] = 6'b01_1110;
    ram[3] = 6'b00_1101;
    ram[4] = 6'b10_1011;
    writeCtl(1'b0, 1'b0, 1'b0, 1'b1, 4'h4, 4'h2);
    clearLog();
    writeReg(1'b0, 16'h8000 | (16'd3 << 8) | 16'd5);
    waitIdle();
    repeat (20) @(negedge clk);
    chk(nStarts == 3, "R5 start count", nStarts, 3);
    chk(startIdx[0] == 2, "R4 first index", startIdx[0], 2);
    chk(startIdx[1] == 3, "R4 second index", startIdx[1], 3);
    chk(startIdx[2] == 4, "R4 third index", startIdx[2], 4);
    chk(startCs[0] == 4'hE, "R4 cs pattern 0", startCs[0], 4'hE);
    chk(startCs[2] == 4'hB, "R4 cs pattern 2", startCs[2], 4'hB);
    chk(preLen[0] == 3, "R7 lead flag set", preLen[0], 3);
    chk(preLen[1] == SCK, "R7 lead default", preLen[1], SCK);
    chk(postLen[0] == SCK, "R8 trail default", postLen[0], SCK);
    chk(postLen[2] == 5, "R8 trail flag set", postLen[2], 5);
    readReg(1'b1, d); chk(d[7:4] == 4'h4, "R6 completed index", d[7:4], 4);
    chk(csOut == 4'hF, "R12 idle level after run", csOut, 4'hF);
  endtask

  task automatic t_zero();
    ram[7] = 6'b11_0111;
    writeCtl(1'b0, 1'b0, 1'b0, 1'b1, 4'h7, 4'h7);
    clearLog();
    writeReg(1'b0, 16'h8000);
    waitIdle();
    repeat (10) @(negedge clk);
    chk(nStarts == 1, "R5 single entry", nStarts, 1);
    chk(preLen[0] == 128, "R7 zero lead", preLen[0], 128);
    chk(postLen[0] == 256, "R8 zero trail", postLen[0], 256);
  endtask

  task automatic t_wrapZero();
    logic [15:0] d;
    int n;
    for (int i = 0; i < 16; i++) ram[i] = 6'b00_0000 | 6'(i[3:0] == 4'hF ? 4'h7 : 4'hE);
    writeCtl(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hE);
    clearLog();
    writeReg(1'b0, 16'h8000 | 16'h0202);
    waitStarts(4);
    writeCtl(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'hE);
    repeat (300) @(negedge clk);
    chk(startIdx[1] == 15 && startIdx[2] == 0, "R11 wrap to entry 0",
        startIdx[2], 0);
    chk(startIdx[3] == 1, "R4 ascending after wrap", startIdx[3], 1);
    chk(nStarts == 4, "R9 no start while paused", nStarts, 4);
    readReg(1'b1, d); chk(d[7:4] == 4'h1, "R6/R9 in-flight command finished", d[7:4], 1);
    readReg(1'b0, d); chk(d[15] == 1'b1, "R9 run stays set", d[15], 1);
    chk(csOut == 4'hF, "R12 idle level while paused", csOut, 4'hF);
    writeCtl(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hE);
    waitStarts(5);
    chk(startIdx[4] == 2, "R9 resume at next entry", startIdx[4], 2);
    writeReg(1'b0, 16'h0202);
    @(negedge clk);
    chk(csOut == 4'hF, "R10 abort idles cs", csOut, 4'hF);
    readReg(1'b0, d); chk(d[15] == 1'b0, "R10 abort clears run", d[15], 0);
    n = nStarts;
    repeat (100) @(negedge clk);
    chk(nStarts == n, "R10 no start after abort", nStarts, n);
  endtask

  task automatic t_wrapNew();
    logic [15:0] d;
    ram[5] = 6'b00_0001;
    ram[6] = 6'b00_0010;
    writeCtl(1'b0, 1'b1, 1'b1, 1'b0, 4'h6, 4'h5);
    repeat (2) @(negedge clk);
    chk(csOut == 4'h0, "R12 idle level low", csOut, 0);
    clearLog();
    writeReg(1'b0, 16'h8000 | 16'h0202);
    waitStarts(4);
    chk(startIdx[2] == 5 && startIdx[3] == 6, "R11 wrap to start index",
        startIdx[2], 5);
    abortLock = 1'b1;
    writeReg(1'b0, 16'h0202);
    readReg(1'b0, d); chk(d[15] == 1'b1, "R10 lock keeps run", d[15], 1);
    waitStarts(6);
    chk(nStarts >= 6, "R10 lock keeps running", nStarts, 6);
    abortLock = 1'b0;
    writeReg(1'b0, 16'h0202);
    @(negedge clk);
    chk(csOut == 4'h0, "R10 abort idles cs low", csOut, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_zero();
    t_wrapZero();
    t_wrapNew();
    summary();
    $finish;
  end
endmodule